// File: doc/BRIEF.md
# Output Clock Router

This block distributes two clock sources over four output lanes. One source carries the modulated (spread) clock and the other carries the plain reference clock. Each lane picks one of the two sources and divides it by a whole number from 1 to 32. A ratio of 1 passes the source level straight through. Each lane also drives its own pad-enable.

Two complete lane configurations are held at the inputs. A select pin chooses which one applies to all lanes. A new setting reaches a lane only while that lane's output is low, so a change never shortens a pulse.

Two controls take the pads off the line:
- Dropping the enable pin releases the pads but leaves the dividers running.
- The active-low power-down pin freezes and clears every lane at once. When it is released, the pads stay off until a programmable number of reference rising edges has passed.

The block runs on a fast system clock. Both sources are sampled as levels, so their rising edges are detected inside that clock domain. All inputs are assumed to be synchronous to `clk`.

Top module: `clk_out_router`

## Requirements
- R1: Each lane `g` reads a 6-bit field at bits `[6g+5:6g]` of the active bank. Bit 5 of the field selects the source: 0 is the spread input and 1 is the reference input. Bits 4:0 hold the divide ratio minus one.
- R2: With a ratio of 1, the lane output repeats the sampled level of its source two `clk` cycles after the source input changes. The high and low widths are kept.
- R3: With a ratio N from 2 to 32, the lane output has a period of N source cycles. It stays high for floor(N/2) source cycles, which gives a 50% duty cycle for even N. For odd N the high phase is one source cycle shorter than the low phase.
- R4: When `fs` is 0, every lane runs from `bank0_cfg`. When `fs` is 1, every lane runs from `bank1_cfg`.
- R5: A lane takes a new setting only while its output is low. After the change, the output stays low until the next rising edge of the new source, and then starts a full high phase. No high pulse is ever cut short.
- R6: While `oe` is 0, every drive-enable goes to 0 and the outputs keep toggling. When `oe` returns to 1, the enables come back. Each enable changes only while its own output is low.
- R7: One cycle after `pd_n` is sampled low, all outputs and all drive-enables are 0, and the dividers are cleared.
- R8: After `pd_n` rises, and also after reset, all enables stay 0 until `settle_len` reference rising edges have been counted. The enables then return with every output low.
- R9: Lanes given the same setting and released together from power-down produce identical outputs on every cycle.
- R10: During reset, all outputs and all drive-enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than both sources |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_clk | input | 1 | Modulated source clock level |
| ref_clk | input | 1 | Unmodulated reference clock level |
| fs | input | 1 | Bank select: 0 picks bank0, 1 picks bank1 |
| oe | input | 1 | Pad enable request for all lanes |
| pd_n | input | 1 | Active-low power-down |
| settle_len | input | 8 | Reference rising edges to wait after power-up |
| bank0_cfg | input | 24 | Lane settings, bank 0 (6 bits per lane) |
| bank1_cfg | input | 24 | Lane settings, bank 1 (6 bits per lane) |
| clk_out | output | 4 | Lane clock outputs |
| drv_en | output | 4 | Per-lane pad drive-enable |

## Verification
A request to change a lane's setting can arrive in the same cycle as that lane is about to raise its output. The change must win and hold the output low, so that no short high pulse appears. The sweep rewrites all four lanes while they sit at random phases and runs about sixty of these changes. A monitor flags any high pulse narrower than the shortest legal one. Power-down and the enable drop can also meet a high phase. The bench judges these by checking that every enable edge follows a low output sample, and that outputs are low in the cycle after power-down.

// File: rtl/clk_router_pkg.sv
package clk_router_pkg;
  localparam int DIV_W = 5;

  typedef struct packed {
    logic             use_ref;
    logic [DIV_W-1:0] div_m1;
  } ch_cfg_t;

  localparam int CFG_W = $bits(ch_cfg_t);
endpackage

// File: rtl/cr_edge_sense.sv
module cr_edge_sense #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  output logic [NSRC-1:0] lvl_q,
  output logic [NSRC-1:0] rise
);
  logic [NSRC-1:0] dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      dly_q <= '0;
    end else begin
      lvl_q <= src_in;
      dly_q <= lvl_q;
    end
  end

  assign rise = lvl_q & ~dly_q;
endmodule

// File: rtl/cr_settle.sv
module cr_settle #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_n,
  input  logic          ref_rise,
  input  logic [CW-1:0] limit,
  output logic          done_q
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic          done_n;

  always_comb begin
    cnt_n  = cnt_q;
    done_n = done_q;
    if (!pd_n) begin
      cnt_n  = '0;
      done_n = 1'b0;
    end else if (!done_q) begin
      if (cnt_q == limit) done_n = 1'b1;
      else if (ref_rise)  cnt_n  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  // R8: ready only ever rises while power-down is released
  a_r8_ready_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(pd_n));
endmodule

// File: rtl/cr_lane.sv
module cr_lane
  import clk_router_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  logic    oe,
  input  ch_cfg_t pend,
  input  logic    spr_lvl,
  input  logic    spr_rise,
  input  logic    ref_lvl,
  input  logic    ref_rise,
  output logic    out_q,
  output logic    en_q
);
  ch_cfg_t          act_q, act_n;
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             hold_q, hold_n, out_n, en_n;
  logic             lvl, rise, bypass;
  logic [DIV_W:0]   half;

  always_comb begin
    lvl    = act_q.use_ref ? ref_lvl  : spr_lvl;
    rise   = act_q.use_ref ? ref_rise : spr_rise;
    bypass = (act_q.div_m1 == '0);
    half   = ({1'b0, act_q.div_m1} + 1'b1) >> 1;
    act_n  = act_q;
    cnt_n  = cnt_q;
    hold_n = hold_q;
    if (!run || (!out_q && (pend != act_q))) begin
      act_n  = pend;
      cnt_n  = '0;
      hold_n = 1'b1;
    end else if (rise) begin
      if (hold_q) begin
        hold_n = 1'b0;
        cnt_n  = '0;
      end else if (cnt_q == act_q.div_m1) begin
        cnt_n = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
    out_n = run && !hold_n && (bypass ? lvl : ({1'b0, cnt_n} < half));
    en_n  = en_q;
    if (!run)       en_n = 1'b0;
    else if (!out_q) en_n = oe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      cnt_q  <= '0;
      hold_q <= 1'b1;
      out_q  <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      act_q  <= act_n;
      cnt_q  <= cnt_n;
      hold_q <= hold_n;
      out_q  <= out_n;
      en_q   <= en_n;
    end
  end

  // R5: setting swaps only happen behind a low output
  a_r5_swap_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && (act_q != $past(act_q))) |-> !$past(out_q));
  // R6: pad enable edges only behind a low output
  a_r6_en_edge_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && (en_q != $past(en_q))) |-> !$past(out_q));
  // R3: divider phase never exceeds the programmed ratio
  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= act_q.div_m1);
endmodule

// File: rtl/clk_out_router.sv
module clk_out_router
  import clk_router_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int SETTLE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spread_clk,
  input  logic                   ref_clk,
  input  logic                   fs,
  input  logic                   oe,
  input  logic                   pd_n,
  input  logic [SETTLE_W-1:0]    settle_len,
  input  logic [LANES*CFG_W-1:0] bank0_cfg,
  input  logic [LANES*CFG_W-1:0] bank1_cfg,
  output logic [LANES-1:0]       clk_out,
  output logic [LANES-1:0]       drv_en
);
  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic [1:0] src_lvl, src_rise;
  logic       settled, run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  cr_edge_sense #(.NSRC(2)) u_sense (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .src_in ({ref_clk, spread_clk}),
    .lvl_q  (src_lvl),
    .rise   (src_rise)
  );

  cr_settle #(.CW(SETTLE_W)) u_settle (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pd_n     (pd_n),
    .ref_rise (src_rise[1]),
    .limit    (settle_len),
    .done_q   (settled)
  );

  assign run = pd_n && settled;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ch_cfg_t pend;
    assign pend = fs ? ch_cfg_t'(bank1_cfg[g*CFG_W +: CFG_W])
                     : ch_cfg_t'(bank0_cfg[g*CFG_W +: CFG_W]);
    cr_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .run      (run),
      .oe       (oe),
      .pend     (pend),
      .spr_lvl  (src_lvl[0]),
      .spr_rise (src_rise[0]),
      .ref_lvl  (src_lvl[1]),
      .ref_rise (src_rise[1]),
      .out_q    (clk_out[g]),
      .en_q     (drv_en[g])
    );
  end

  // R7: power-down silences every lane on the next cycle
  a_r7_pd_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    !pd_n |=> (clk_out == '0 && drv_en == '0));
endmodule

// File: tb/test_clk_out_router.sv
module test_clk_out_router;
  localparam int CLK_PERIOD = 10;
  localparam int SP = 4;
  localparam int RP = 6;

  logic        clk = 1'b0;
  logic        rst_n, spread_clk, ref_clk, fs, oe, pd_n;
  logic [7:0]  settle_len;
  logic [23:0] bank0, bank1;
  logic [3:0]  clk_out, drv_en;

  int  checks = 0;
  int  errors = 0;
  bit  pd_window = 1'b1;
  bit  done_flag = 1'b0;

  clk_out_router i_clk_out_router (
    .clk(clk), .rst_n(rst_n), .spread_clk(spread_clk), .ref_clk(ref_clk),
    .fs(fs), .oe(oe), .pd_n(pd_n), .settle_len(settle_len),
    .bank0_cfg(bank0), .bank1_cfg(bank1), .clk_out(clk_out), .drv_en(drv_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int sc, rc;
    spread_clk = 1'b0; ref_clk = 1'b0; sc = 0; rc = 0;
    forever begin
      @(negedge clk);
      sc++; rc++;
      if (sc == SP/2) begin spread_clk = ~spread_clk; sc = 0; end
      if (rc == RP/2) begin ref_clk = ~ref_clk; rc = 0; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [5:0] fld(input bit use_ref, input int ratio);
    return {use_ref, 5'(ratio - 1)};
  endfunction

  // R5: no high pulse narrower than the shortest legal high (2 cycles here)
  int hw [4];
  int runts = 0;
  initial begin
    for (int k = 0; k < 4; k++) hw[k] = 0;
    forever begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        if (clk_out[k] === 1'b1) hw[k]++;
        else begin
          if (hw[k] > 0 && hw[k] < 2 && !pd_window) begin
            runts++;
            $display("FAIL R5 lane %0d high width actual=%0d expected>=%0d", k, hw[k], 2);
          end
          hw[k] = 0;
        end
      end
    end
  end

  task automatic measure(input int k, input int n, input bit use_ref, input string tag);
    int p, eh, ep, hi, lo, guard;
    p  = use_ref ? RP : SP;
    eh = (n == 1) ? p / 2 : (n / 2) * p;
    ep = n * p;
    hi = 0; lo = 0; guard = 0;
    while (clk_out[k] !== 1'b0 && guard < 2000) begin @(negedge clk); guard++; end
    while (clk_out[k] !== 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
    while (clk_out[k] === 1'b1 && guard < 2000) begin hi++; @(negedge clk); guard++; end
    while (clk_out[k] === 1'b0 && guard < 2000) begin lo++; @(negedge clk); guard++; end
    check(hi == eh, tag, hi, eh);
    check(hi + lo == ep, tag, hi + lo, ep);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int t, first, togg;
    bit prev;
    logic [3:0] pe, po;
    rst_n = 1'b0; fs = 1'b0; oe = 1'b1; pd_n = 1'b1; settle_len = 8'd0;
    bank0 = '0; bank1 = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(clk_out == 4'h0, "R10 outputs in reset", clk_out, 0);
    check(drv_en == 4'h0, "R10 enables in reset", drv_en, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    pd_window = 1'b0;

    // R1 R2 R3: sweep every ratio on both sources over all lanes
    for (int step = 0; step < 32; step++) begin
      for (int s = 0; s < 2; s++) begin
        for (int k = 0; k < 4; k++)
          bank0[6*k +: 6] = fld(1'(s ^ (k & 1)), ((step + 8*k) % 32) + 1);
        repeat (400) @(negedge clk);
        fork
          measure(0, ((step + 0) % 32) + 1, 1'(s ^ 0), "R1 R2 R3 lane0");
          measure(1, ((step + 8) % 32) + 1, 1'(s ^ 1), "R1 R2 R3 lane1");
          measure(2, ((step + 16) % 32) + 1, 1'(s ^ 0), "R1 R2 R3 lane2");
          measure(3, ((step + 24) % 32) + 1, 1'(s ^ 1), "R1 R2 R3 lane3");
        join
      end
    end
    check(runts == 0, "R5 runt pulses during swaps", runts, 0);

    // R4: bank select
    for (int k = 0; k < 4; k++) begin
      bank0[6*k +: 6] = fld(1'b0, 2);
      bank1[6*k +: 6] = fld(1'b1, 4 + k);
    end
    fs = 1'b1;
    repeat (200) @(negedge clk);
    fork
      measure(0, 4, 1'b1, "R4 fs=1 lane0");
      measure(3, 7, 1'b1, "R4 fs=1 lane3");
    join
    fs = 1'b0;
    repeat (200) @(negedge clk);
    fork
      measure(0, 2, 1'b0, "R4 fs=0 lane0");
      measure(3, 2, 1'b0, "R4 fs=0 lane3");
    join

    // R6: output enable drop
    for (int k = 0; k < 4; k++) bank0[6*k +: 6] = fld(1'b0, 8);
    repeat (100) @(negedge clk);
    pe = drv_en; po = clk_out;
    oe = 1'b0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++)
        if (drv_en[k] != pe[k]) check(po[k] == 1'b0, "R6 enable fell on low", po[k], 0);
      pe = drv_en; po = clk_out;
    end
    check(drv_en == 4'h0, "R6 enables off", drv_en, 0);
    togg = 0; prev = clk_out[0];
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      if (clk_out[0] != prev) togg++;
      prev = clk_out[0];
    end
    check(togg > 0, "R6 outputs keep running", togg, 1);
    oe = 1'b1;
    pe = drv_en; po = clk_out;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++)
        if (drv_en[k] != pe[k]) check(po[k] == 1'b0, "R6 enable rose on low", po[k], 0);
      pe = drv_en; po = clk_out;
    end
    check(drv_en == 4'hF, "R6 enables back", drv_en, 15);

    // R7 R8 R9: power-down, settle, fan-out
    for (int k = 0; k < 4; k++) bank0[6*k +: 6] = fld(1'b1, 3);
    settle_len = 8'd5;
    pd_window = 1'b1;
    pd_n = 1'b0;
    @(negedge clk);
    check(clk_out == 4'h0, "R7 outputs low in power-down", clk_out, 0);
    check(drv_en == 4'h0, "R7 enables off in power-down", drv_en, 0);
    repeat (10) @(negedge clk);
    pd_n = 1'b1;
    first = -1;
    for (t = 1; t <= 60; t++) begin
      @(negedge clk);
      if (t == 20) check(drv_en == 4'h0, "R8 enables held while settling", drv_en, 0);
      if (first < 0 && drv_en != 4'h0) begin
        first = t;
        check(drv_en == 4'hF, "R8 enables return together", drv_en, 15);
        check(clk_out == 4'h0, "R8 outputs low at return", clk_out, 0);
      end
    end
    check(first >= 24 && first <= 45, "R8 settle length", first, 30);
    pd_window = 1'b0;
    togg = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (clk_out != 4'h0 && clk_out != 4'hF) togg++;
    end
    check(togg == 0, "R9 identical lanes match", togg, 0);
    measure(2, 3, 1'b1, "R9 R3 fan-out lane2");
    check(runts == 0, "R5 runt pulses overall", runts, 0);
    finish_run();
  end
endmodule